// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block sits inside a chip's reset unit and decides which reset sequence to run. Its requests come from three asynchronous active-low pins (power-on, pushbutton warm and pushbutton externally-initiated interrupt, "XINT"), from a software generate register, from a frequency-change request, and from single-cycle fatal-error pulses from a non-cacheable unit and from eight cache slices. It grants one reset at a time: power-on, warm, debug or XINT.

Every request is recorded in a source register, and software clears its bits by writing ones. A status register holds the type of the latest power-on, warm or frequency-change reset, with shadow copies of the reset before it. The cache-slice fatal errors only act when their bits in an enable register are set, and a warm or power-on reset clears that register. Power-on, warm and debug sequences end with a one-cycle unpark pulse. An XINT sequence holds a request to the non-cacheable unit until that unit answers with a done signal.

A separate subsystem register gives a timed, isolated warm reset to the network unit or to the DMA/PCIe unit. Software reaches all of these registers through a simple write-strobe port with a combinational read.

Top module: `rstcause_ctrl`

## Requirements
- R1: When requests arrive in the same cycle, the grant goes to power-on first, then warm, then frequency-change (reported as warm), then debug, then XINT. `rst_kind` shows the grant while `rst_busy` is high: 1 power-on, 2 warm, 3 debug, 4 XINT, and 0 when idle.
- R2: A request that arrives while a sequence runs sets its source bit but neither restarts nor extends the sequence, and it produces no second sequence afterwards.
- R3: Source register (address 2) bits: 0 software warm, 1 software XINT, 3 software debug, 4 power-on pin, 5 pushbutton warm pin, 6 pushbutton XINT pin, 7 non-cacheable fatal, 8+i cache slice i fatal. Each bit is set in the cycle its request is detected.
- R4: Writing to the source register clears every bit written as 1 and leaves the other bits alone. Writing all ones clears the register.
- R5: Status register (address 3): bits 0/1/2 are power-on/warm/frequency, and bits 4/5/6 are their shadows. When a power-on, warm or frequency-change reset is granted, the old bits 0..2 are first copied into bits 4..6. Then power-on writes 1/0/0, warm writes 0/1/0 and frequency-change writes 0/1/1.
- R6: Debug and XINT resets leave the status register unchanged.
- R7: A fatal pulse from cache slice i starts a warm reset and sets its source bit only while bit 8+i of the enable register (address 4) is set. Otherwise it has no effect.
- R8: A granted power-on or warm (including frequency-change) reset clears the fatal enable register to zero.
- R9: A single-cycle pulse on `nc_fatal` starts a warm reset.
- R10: Power-on, warm and debug sequences last SEQ_CYCLES cycles and then assert `unpark` for exactly one cycle. An XINT sequence asserts no `unpark`. It holds `xint_req` high until `xint_done` is seen, and then goes idle.
- R11: Writing 1 to bit 0 or bit 1 of the subsystem register (address 1) drives `niu_rst_n` or `dma_rst_n` low for SSYS_CYCLES cycles. The other subsystem is not touched.
- R12: Each pin is synchronized through two flops, and a request is taken only on a falling edge. A pin held low gives one request, and its release gives none.
- R13: After `rst_n`, the source, status and enable registers read 0, the block is idle, and both subsystem resets are high.
- R14: Writing the generate register (address 0) with bit 0, bit 1 or bit 3 set requests a warm, XINT or debug reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_pin_n | input | 1 | Power-on request pin, active low, asynchronous |
| pbw_pin_n | input | 1 | Pushbutton warm reset pin, active low, asynchronous |
| pbx_pin_n | input | 1 | Pushbutton XINT pin, active low, asynchronous |
| clk_change_req | input | 1 | Frequency-change reset request pulse |
| nc_fatal | input | 1 | Non-cacheable unit fatal error pulse |
| slice_fatal | input | N_SLICE | Cache-slice fatal error pulses |
| xint_done | input | 1 | Completion of an XINT from the non-cacheable unit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on reg_addr) |
| rst_busy | output | 1 | A reset sequence is running |
| rst_kind | output | 3 | Granted reset type |
| unpark | output | 1 | One-cycle end-of-sequence pulse for power-on, warm or debug |
| xint_req | output | 1 | XINT pending at the non-cacheable unit |
| niu_rst_n | output | 1 | Network unit warm reset, active low |
| dma_rst_n | output | 1 | DMA/PCIe unit warm reset, active low |

## Verification
A corrupted sequencer state is visible within SEQ_CYCLES+2 cycles: a missing or doubled `unpark`, a second rise of `rst_busy`, or an `xint_req` that drops before `xint_done`. A wrong grant appears on `rst_kind` in the first busy cycle and in the status register read after it. The status read also exposes a lost shadow copy as soon as the next power-on, warm or frequency reset is granted. Source and enable register faults appear on the next read after the pulse or write concerned, including after single-cycle fatal pulses and pins held low for many cycles.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE = 3'd0,
    KIND_PWR  = 3'd1,
    KIND_WARM = 3'd2,
    KIND_DBG  = 3'd3,
    KIND_XINT = 3'd4
  } rst_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_XWAIT = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam logic [2:0] ADDR_GEN  = 3'd0;
  localparam logic [2:0] ADDR_SSYS = 3'd1;
  localparam logic [2:0] ADDR_SRC  = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_FEE  = 3'd4;

  localparam int GEN_WARM_BIT = 0;
  localparam int GEN_XINT_BIT = 1;
  localparam int GEN_DBG_BIT  = 3;

  localparam int SRC_SW_WARM    = 0;
  localparam int SRC_SW_XINT    = 1;
  localparam int SRC_SW_DBG     = 3;
  localparam int SRC_PIN_PWR    = 4;
  localparam int SRC_PIN_WARM   = 5;
  localparam int SRC_PIN_XINT   = 6;
  localparam int SRC_NC_FATAL   = 7;
  localparam int SRC_SLICE_BASE = 8;

  localparam int N_SUBSYS = 2;
  localparam int PIN_PWR  = 0;
  localparam int PIN_WARM = 1;
  localparam int PIN_XINT = 2;
  localparam int N_PINS   = 3;

  typedef struct packed {
    logic pwr;
    logic warm;
    logic freq;
    logic dbg;
    logic xint;
  } req_t;

  typedef struct packed {
    logic freq_s;
    logic warm_s;
    logic pwr_s;
    logic freq;
    logic warm;
    logic pwr;
  } stat_t;

endpackage

// File: rtl/rcc_pin_sync.sv
module rcc_pin_sync #(
  parameter int N_PIN  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_n,
  output logic [N_PIN-1:0] fall
);

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-1:0], pin_n[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end

    // stage STAGES-1 is the synchronized level, stage STAGES the previous one
    assign fall[g] = sh_q[STAGES] & ~sh_q[STAGES-1];

    p_single_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fall[g] |=> !fall[g]);
  end

endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
  import rcc_pkg::*;
#(
  parameter int SEQ_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  req_t      req,
  input  logic      xint_done,
  output logic      busy,
  output rst_kind_e kind,
  output logic      unpark,
  output logic      xint_req,
  output logic      fee_clr,
  output stat_t     status
);

  localparam int CNT_W = (SEQ_CYCLES > 1) ? $clog2(SEQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEQ_CYCLES - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  rst_kind_e        kind_q, kind_d;
  stat_t            stat_q, stat_d;
  rst_kind_e        pick;
  logic             any_req;
  logic             grant;

  always_comb begin
    any_req = |req;
    if (req.pwr)                  pick = KIND_PWR;
    else if (req.warm || req.freq) pick = KIND_WARM;
    else if (req.dbg)             pick = KIND_DBG;
    else if (req.xint)            pick = KIND_XINT;
    else                          pick = KIND_IDLE;
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    stat_d  = stat_q;
    grant   = 1'b0;
    fee_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (any_req) begin
          grant  = 1'b1;
          st_d   = ST_RUN;
          cnt_d  = '0;
          kind_d = pick;
          if (pick == KIND_PWR || pick == KIND_WARM) begin
            fee_clr       = 1'b1;
            stat_d.pwr_s  = stat_q.pwr;
            stat_d.warm_s = stat_q.warm;
            stat_d.freq_s = stat_q.freq;
            if (pick == KIND_PWR) begin
              stat_d.pwr  = 1'b1;
              stat_d.warm = 1'b0;
              stat_d.freq = 1'b0;
            end else begin
              stat_d.pwr  = 1'b0;
              stat_d.warm = 1'b1;
              stat_d.freq = req.freq && !req.warm;
            end
          end
        end
      end
      ST_RUN: begin
        if (cnt_q == CNT_LAST) st_d = (kind_q == KIND_XINT) ? ST_XWAIT : ST_DONE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_XWAIT: begin
        if (xint_done) begin
          st_d   = ST_IDLE;
          kind_d = KIND_IDLE;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        kind_d = KIND_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      kind_q <= KIND_IDLE;
      stat_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      stat_q <= stat_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign kind     = kind_q;
  assign unpark   = (st_q == ST_DONE);
  assign xint_req = (st_q == ST_XWAIT);
  assign status   = stat_q;

  p_pwr_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req.pwr) |=> (kind == KIND_PWR));

  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> (busy && $stable(kind)));

  p_shadow_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (pick == KIND_PWR || pick == KIND_WARM)) |=>
      (status.pwr_s == $past(status.pwr) && status.warm_s == $past(status.warm)
       && status.freq_s == $past(status.freq)));

  p_dbg_keeps_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (pick == KIND_DBG || pick == KIND_XINT)) |=> $stable(status));

  p_unpark_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unpark |=> !unpark);

  p_xint_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xint_req && !xint_done) |=> xint_req);

  p_xint_no_unpark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xint_req |-> !unpark);

endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
#(
  parameter int N_SLICE     = 8,
  parameter int SSYS_CYCLES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [2:0]               addr,
  input  logic [8+N_SLICE-1:0]     wdata,
  output logic [8+N_SLICE-1:0]     rdata,
  input  logic [8+N_SLICE-1:0]     src_set,
  input  stat_t                    status,
  input  logic                     fee_clr,
  output logic                     gen_warm,
  output logic                     gen_xint,
  output logic                     gen_dbg,
  output logic [N_SLICE-1:0]       fee_en,
  output logic                     niu_rst_n,
  output logic                     dma_rst_n
);

  localparam int DW    = 8 + N_SLICE;
  localparam int SCW   = $clog2(SSYS_CYCLES + 1);
  localparam logic [SCW-1:0] SS_LOAD = SCW'(SSYS_CYCLES);

  logic            wr_gen, wr_ssys, wr_src, wr_fee;
  logic [DW-1:0]   src_q, src_d;
  logic [N_SLICE-1:0] fee_q, fee_d;
  logic [N_SUBSYS-1:0] ss_active;

  always_comb begin
    wr_gen  = we && (addr == ADDR_GEN);
    wr_ssys = we && (addr == ADDR_SSYS);
    wr_src  = we && (addr == ADDR_SRC);
    wr_fee  = we && (addr == ADDR_FEE);
  end

  assign gen_warm = wr_gen && wdata[GEN_WARM_BIT];
  assign gen_xint = wr_gen && wdata[GEN_XINT_BIT];
  assign gen_dbg  = wr_gen && wdata[GEN_DBG_BIT];

  // source: write-one-to-clear, a new cause wins over a clear
  always_comb begin
    src_d = src_q;
    if (wr_src) src_d = src_d & ~wdata;
    src_d = src_d | src_set;
  end

  // fatal enable: the reset clear wins over a write in the same cycle
  always_comb begin
    fee_d = fee_q;
    if (wr_fee)  fee_d = wdata[DW-1:8];
    if (fee_clr) fee_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      fee_q <= '0;
    end else begin
      src_q <= src_d;
      fee_q <= fee_d;
    end
  end

  assign fee_en = fee_q;

  for (genvar g = 0; g < N_SUBSYS; g++) begin : g_ssys
    logic [SCW-1:0] cnt_q, cnt_d;
    logic           cnt_en;

    always_comb begin
      cnt_en = 1'b0;
      cnt_d  = cnt_q;
      if (wr_ssys && wdata[g]) begin
        cnt_en = 1'b1;
        cnt_d  = SS_LOAD;
      end else if (cnt_q != '0) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign ss_active[g] = (cnt_q != '0);

    p_ssys_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ssys && wdata[g]) |=> ss_active[g]);
  end

  assign niu_rst_n = ~ss_active[0];
  assign dma_rst_n = ~ss_active[1];

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_SSYS: rdata = DW'(ss_active);
      ADDR_SRC:  rdata = src_q;
      ADDR_STAT: rdata = DW'({1'b0, status.freq_s, status.warm_s, status.pwr_s,
                              1'b0, status.freq, status.warm, status.pwr});
      ADDR_FEE:  rdata = {fee_q, 8'b0};
      default:   rdata = '0;
    endcase
  end

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_src |=> ((src_q & $past(wdata & ~src_set)) == '0));

  p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((src_q & $past(src_set)) == $past(src_set)));

  p_fee_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fee_clr |=> (fee_en == '0));

endmodule

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rcc_pkg::*;
#(
  parameter int N_SLICE     = 8,
  parameter int DATA_W      = 8 + N_SLICE,
  parameter int SEQ_CYCLES  = 8,
  parameter int SSYS_CYCLES = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_pin_n,
  input  logic               pbw_pin_n,
  input  logic               pbx_pin_n,
  input  logic               clk_change_req,
  input  logic               nc_fatal,
  input  logic [N_SLICE-1:0] slice_fatal,
  input  logic               xint_done,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               rst_busy,
  output logic [2:0]         rst_kind,
  output logic               unpark,
  output logic               xint_req,
  output logic               niu_rst_n,
  output logic               dma_rst_n
);

  logic [N_PINS-1:0]  pin_fall;
  logic               gen_warm, gen_xint, gen_dbg;
  logic [N_SLICE-1:0] fee_en;
  logic [N_SLICE-1:0] slice_hit;
  logic [DATA_W-1:0]  src_set;
  logic               fee_clr;
  req_t               req;
  stat_t              status;
  rst_kind_e          kind;

  rcc_pin_sync #(.N_PIN(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n ({pbx_pin_n, pbw_pin_n, pwr_pin_n}),
    .fall  (pin_fall)
  );

  assign slice_hit = slice_fatal & fee_en;

  always_comb begin
    req.pwr  = pin_fall[PIN_PWR];
    req.warm = pin_fall[PIN_WARM] | gen_warm | nc_fatal | (|slice_hit);
    req.freq = clk_change_req;
    req.dbg  = gen_dbg;
    req.xint = pin_fall[PIN_XINT] | gen_xint;
  end

  always_comb begin
    src_set = '0;
    src_set[SRC_SW_WARM]  = gen_warm;
    src_set[SRC_SW_XINT]  = gen_xint;
    src_set[SRC_SW_DBG]   = gen_dbg;
    src_set[SRC_PIN_PWR]  = pin_fall[PIN_PWR];
    src_set[SRC_PIN_WARM] = pin_fall[PIN_WARM];
    src_set[SRC_PIN_XINT] = pin_fall[PIN_XINT];
    src_set[SRC_NC_FATAL] = nc_fatal;
    src_set[SRC_SLICE_BASE +: N_SLICE] = slice_hit;
  end

  rcc_seq #(.SEQ_CYCLES(SEQ_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .xint_done (xint_done),
    .busy      (rst_busy),
    .kind      (kind),
    .unpark    (unpark),
    .xint_req  (xint_req),
    .fee_clr   (fee_clr),
    .status    (status)
  );

  assign rst_kind = kind;

  rcc_regs #(.N_SLICE(N_SLICE), .SSYS_CYCLES(SSYS_CYCLES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .src_set   (src_set),
    .status    (status),
    .fee_clr   (fee_clr),
    .gen_warm  (gen_warm),
    .gen_xint  (gen_xint),
    .gen_dbg   (gen_dbg),
    .fee_en    (fee_en),
    .niu_rst_n (niu_rst_n),
    .dma_rst_n (dma_rst_n)
  );

  p_gated_slice_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_busy && (slice_fatal & fee_en) != '0) |=> rst_busy);

  p_nc_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_busy && nc_fatal) |=> (rst_busy && rst_kind != 3'd0));

endmodule

// File: tb/rstcause_ctrl_tb.sv
module rstcause_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_SLICE = 8;
  localparam int DW = 8 + N_SLICE;
  localparam int SEQ = 8;
  localparam int SSYS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_pin_n = 1'b1, pbw_pin_n = 1'b1, pbx_pin_n = 1'b1;
  logic clk_change_req = 1'b0, nc_fatal = 1'b0, xint_done = 1'b0;
  logic [N_SLICE-1:0] slice_fatal = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic rst_busy, unpark, xint_req, niu_rst_n, dma_rst_n;
  logic [2:0] rst_kind;

  int n_chk = 0, n_fail = 0;
  int n_unpark = 0, n_start = 0;
  logic busy_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstcause_ctrl #(.N_SLICE(N_SLICE), .SEQ_CYCLES(SEQ), .SSYS_CYCLES(SSYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_pin_n(pwr_pin_n), .pbw_pin_n(pbw_pin_n),
    .pbx_pin_n(pbx_pin_n), .clk_change_req(clk_change_req), .nc_fatal(nc_fatal),
    .slice_fatal(slice_fatal), .xint_done(xint_done), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_busy(rst_busy), .rst_kind(rst_kind), .unpark(unpark), .xint_req(xint_req),
    .niu_rst_n(niu_rst_n), .dma_rst_n(dma_rst_n)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (unpark) n_unpark++;
      if (rst_busy && !busy_d) n_start++;
    end
    busy_d = rst_busy;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic wait_start(output int k);
    k = -1;
    for (int i = 0; i < 20; i++) begin
      if (rst_busy) begin k = int'(rst_kind); break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!rst_busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_src();
    reg_wr(3'd2, '1);
  endtask

  task automatic t_reset();
    int v;
    chk(!rst_busy && rst_kind == 3'd0 && !unpark && !xint_req, "R13 idle", int'(rst_busy), 0);
    chk(niu_rst_n && dma_rst_n, "R13 ssys high", int'({niu_rst_n, dma_rst_n}), 3);
    reg_rd(3'd2, v); chk(v == 0, "R13 source", v, 0);
    reg_rd(3'd3, v); chk(v == 0, "R13 status", v, 0);
    reg_rd(3'd4, v); chk(v == 0, "R13 enable", v, 0);
  endtask

  task automatic t_sw_priority();
    int k, v, u0;
    u0 = n_unpark;
    reg_wr(3'd0, DW'(16'h000B));
    wait_start(k);
    chk(k == 2, "R1 R14 warm over debug/xint", k, 2);
    wait_idle();
    chk(n_unpark == u0 + 1, "R10 one unpark", n_unpark - u0, 1);
    reg_rd(3'd2, v); chk(v == 'h0B, "R3 sw bits", v, 'h0B);
    reg_rd(3'd3, v); chk(v == 'h02, "R5 warm status", v, 'h02);
    clear_src();
    reg_rd(3'd2, v); chk(v == 0, "R4 clear all", v, 0);
  endtask

  task automatic t_pin_por();
    int k, v;
    @(negedge clk); pwr_pin_n = 1'b0; pbw_pin_n = 1'b0;
    wait_start(k);
    chk(k == 1, "R1 R12 power-on over warm pin", k, 1);
    @(negedge clk); pwr_pin_n = 1'b1; pbw_pin_n = 1'b1;
    wait_idle();
    reg_rd(3'd3, v); chk(v == 'h21, "R5 power-on with shadow", v, 'h21);
    reg_rd(3'd2, v); chk(v == 'h30, "R3 pin bits", v, 'h30);
    reg_wr(3'd2, DW'(16'h0010));
    reg_rd(3'd2, v); chk(v == 'h20, "R4 partial clear", v, 'h20);
    clear_src();
  endtask

  task automatic t_dbg_over_xint();
    int k, v;
    reg_wr(3'd0, DW'(16'h000A));
    wait_start(k);
    chk(k == 3, "R1 debug over xint", k, 3);
    wait_idle();
    reg_rd(3'd3, v); chk(v == 'h21, "R6 debug keeps status", v, 'h21);
    reg_rd(3'd2, v); chk(v == 'h0A, "R3 debug/xint bits", v, 'h0A);
    clear_src();
  endtask

  task automatic t_pin_xint();
    int k, v, u0;
    u0 = n_unpark;
    @(negedge clk); pbx_pin_n = 1'b0;
    wait_start(k);
    chk(k == 4, "R12 xint pin kind", k, 4);
    repeat (SEQ + 20) @(negedge clk);
    chk(xint_req && rst_busy, "R10 xint_req held", int'(xint_req), 1);
    @(negedge clk); xint_done = 1'b1;
    @(negedge clk); xint_done = 1'b0;
    chk(!rst_busy && !xint_req, "R10 xint ends on done", int'(rst_busy), 0);
    chk(n_unpark == u0, "R10 no unpark on xint", n_unpark - u0, 0);
    pbx_pin_n = 1'b1;
    wait_idle();
    reg_rd(3'd3, v); chk(v == 'h21, "R6 xint keeps status", v, 'h21);
    reg_rd(3'd2, v); chk(v == 'h40, "R3 xint pin bit", v, 'h40);
    clear_src();
  endtask

  task automatic t_freq();
    int k, v;
    @(negedge clk);
    clk_change_req = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = DW'(16'h0008);
    @(negedge clk);
    clk_change_req = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    wait_start(k);
    chk(k == 2, "R1 frequency over debug", k, 2);
    wait_idle();
    reg_rd(3'd3, v); chk(v == 'h16, "R5 frequency status", v, 'h16);
    clear_src();
  endtask

  task automatic t_busy_request();
    int k, v, u0, s0;
    u0 = n_unpark; s0 = n_start;
    reg_wr(3'd0, DW'(16'h0001));
    wait_start(k);
    repeat (2) @(negedge clk);
    nc_fatal = 1'b1;
    @(negedge clk); nc_fatal = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    chk(n_start == s0 + 1, "R2 no restart", n_start - s0, 1);
    chk(n_unpark == u0 + 1, "R2 single unpark", n_unpark - u0, 1);
    reg_rd(3'd2, v); chk(v == 'h81, "R2 late cause recorded", v, 'h81);
    reg_rd(3'd3, v); chk(v == 'h62, "R5 shadow after frequency", v, 'h62);
    clear_src();
  endtask

  task automatic t_fatal();
    int k, v, s0;
    s0 = n_start;
    @(negedge clk); slice_fatal = 8'h04;
    @(negedge clk); slice_fatal = '0;
    repeat (10) @(negedge clk);
    chk(n_start == s0, "R7 disabled slice ignored", n_start - s0, 0);
    reg_rd(3'd2, v); chk(v == 0, "R7 no source when disabled", v, 0);
    reg_wr(3'd4, DW'(16'h0400));
    reg_rd(3'd4, v); chk(v == 'h400, "R7 enable write", v, 'h400);
    @(negedge clk); slice_fatal = 8'h04;
    @(negedge clk); slice_fatal = '0;
    wait_start(k);
    chk(k == 2, "R7 enabled slice warm", k, 2);
    wait_idle();
    reg_rd(3'd2, v); chk(v == 'h400, "R3 slice bit", v, 'h400);
    reg_rd(3'd4, v); chk(v == 0, "R8 enable cleared", v, 0);
    reg_rd(3'd3, v); chk(v == 'h22, "R5 warm after warm", v, 'h22);
    clear_src();
    @(negedge clk); nc_fatal = 1'b1;
    @(negedge clk); nc_fatal = 1'b0;
    wait_start(k);
    chk(k == 2, "R9 nc pulse warm", k, 2);
    wait_idle();
    reg_rd(3'd2, v); chk(v == 'h80, "R9 nc source", v, 'h80);
    clear_src();
  endtask

  task automatic t_ssys();
    reg_wr(3'd1, DW'(16'h0001));
    chk(!niu_rst_n && dma_rst_n, "R11 niu only", int'({niu_rst_n, dma_rst_n}), 1);
    repeat (SSYS + 2) @(negedge clk);
    chk(niu_rst_n && dma_rst_n, "R11 niu released", int'({niu_rst_n, dma_rst_n}), 3);
    reg_wr(3'd1, DW'(16'h0002));
    chk(niu_rst_n && !dma_rst_n, "R11 dma only", int'({niu_rst_n, dma_rst_n}), 2);
    repeat (SSYS + 2) @(negedge clk);
    chk(niu_rst_n && dma_rst_n && !rst_busy, "R11 dma released", int'({niu_rst_n, dma_rst_n}), 3);
  endtask

  task automatic t_held_pin();
    int s0;
    s0 = n_start;
    @(negedge clk); pbw_pin_n = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_start == s0 + 1, "R12 held pin one request", n_start - s0, 1);
    pbw_pin_n = 1'b1;
    repeat (15) @(negedge clk);
    chk(n_start == s0 + 1, "R12 release no request", n_start - s0, 1);
    clear_src();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sw_priority();
    t_pin_por();
    t_dbg_over_xint();
    t_pin_xint();
    t_freq();
    t_busy_request();
    t_fatal();
    t_ssys();
    t_held_pin();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule